// File: doc/BRIEF.md
# Floating-Point Exception Status Recorder

This block owns a 32-bit floating-point status word and folds into it the exception vector that one arithmetic operation reports. The vector has five flags: invalid, overflow, underflow, divide-by-zero and inexact. The recorder compares the vector with the trap-enable field of the status word to decide whether a trap occurs. It then rewrites the current-exception field, extends the accrued-exception field or marks the trap type, and raises a one-cycle trap request. Computing the flags is the job of the arithmetic units and is outside this block.

A second command runs after a deferred-trap queue has been emptied. It clears the queue-occupancy bits, and it also clears the current-exception field when every queued operation finished without a trap. Software can load the whole word at any time through a write port, and the word is always visible on `status_q`.

A two-state machine sequences the trap request. In `S_IDLE` no trap is pending. The transition `GO_TRAP` fires on any accepted operation whose enabled flags are nonzero and enters `S_TRAP`, which drives `trap_req` for that cycle. From `S_TRAP`, `STAY_TRAP` is taken on another trapping operation and `BACK_IDLE` on anything else. A software write always forces `BACK_IDLE`.

Top module: `fpx_status_rec`

## Requirements
- R1: While reset is asserted and after it is released, `status_q` is zero and `trap_req` is low.
- R2: When `wr_en` is high, `status_q` takes `wr_data` at the next edge and `trap_req` is low. A write takes precedence over an exception or a drain presented in the same cycle, and those are discarded.
- R3: Field layout of `status_q`: trap enables at bits 27:23, accrued flags at 9:5, current flags at 4:0, queue-occupancy at 13:12, trap type at 16:14. Inside each 5-bit field, invalid is bit 4, overflow bit 3, underflow bit 2, divide-by-zero bit 1 and inexact bit 0.
- R4: An accepted exception traps exactly when `exc_vec` AND the enable field is nonzero. `trap_req` is high during the cycle after such an operation is accepted, and low after any other cycle.
- R5: On a trap, the current field holds a single flag: the highest-priority bit of `exc_vec` AND enables, with priority invalid, overflow, underflow, divide-by-zero, inexact.
- R6: A nonzero vector that does not trap writes `exc_vec` into the current field and ORs it into the accrued field.
- R7: On a trap, the accrued field is unchanged, trap-type bit 14 is set, and bits 16:15 are zero.
- R8: A nonzero vector that does not trap leaves trap-type bits 16:14 at zero.
- R9: A zero vector clears the current field, leaves every other bit unchanged and does not trap.
- R10: A drain, with no write or exception in the same cycle, clears bits 13:12. It clears the current field only when `drain_ok` is high. All other bits are kept.
- R11: An exception and a drain in the same cycle: the exception is applied and the drain is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Load the status word from `wr_data` |
| wr_data | input | 32 | Status value to load |
| exc_valid | input | 1 | One operation's exception vector is present |
| exc_vec | input | 5 | Exception flags of that operation |
| drain_req | input | 1 | Deferred-trap queue has been emptied |
| drain_ok | input | 1 | Every queued operation completed without trapping |
| status_q | output | 32 | Current status word |
| trap_req | output | 1 | Trap request, one cycle per trapping operation |

## Verification
The assertions assume that the inputs are stable around the clock edge and known once reset is released. They also assume that a write, an exception and a drain presented together resolve only through the stated precedence. The bench changes its inputs only on the falling edge and drives every input to a defined value on every cycle. Its random phase deliberately overlaps writes, exceptions and drains so that each precedence path is exercised under those assumptions.

// File: rtl/fpx_pkg.sv
package fpx_pkg;
    localparam int EXC_W   = 5;
    localparam int CUR_LSB = 0;
    localparam int ACC_LSB = 5;
    localparam int QNE_LSB = 12;
    localparam int QNE_W   = 2;
    localparam int FTT_LSB = 14;
    localparam int FTT_W   = 3;
    localparam int TEM_LSB = 23;

    typedef enum logic {
        S_IDLE = 1'b0,
        S_TRAP = 1'b1
    } fpx_state_e;
endpackage

// File: rtl/fpx_prio_pick.sv
module fpx_prio_pick #(
    parameter int W = 5
) (
    input  logic [W-1:0] req,
    output logic [W-1:0] pick
);
    // highest index wins: later iterations override earlier ones
    always_comb begin
        pick = '0;
        for (int i = 0; i < W; i++) begin
            if (req[i]) begin
                pick    = '0;
                pick[i] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/fpx_exc_update.sv
module fpx_exc_update
    import fpx_pkg::*;
#(
    parameter int SR_W = 32
) (
    input  logic [SR_W-1:0]  cur,
    input  logic [EXC_W-1:0] vec,
    output logic [SR_W-1:0]  nxt,
    output logic             trap
);
    logic [EXC_W-1:0] enabled;
    logic [EXC_W-1:0] single;
    logic [EXC_W-1:0] result;

    assign enabled = vec & cur[TEM_LSB +: EXC_W];
    assign trap    = |enabled;

    fpx_prio_pick #(.W(EXC_W)) pick_i (
        .req  (enabled),
        .pick (single)
    );

    assign result = trap ? single : vec;

    always_comb begin
        nxt = cur;
        nxt[CUR_LSB +: EXC_W] = result;
        if (vec != '0) begin
            nxt[FTT_LSB +: FTT_W] = '0;
            if (trap) begin
                nxt[FTT_LSB] = 1'b1;
            end else begin
                nxt[ACC_LSB +: EXC_W] = cur[ACC_LSB +: EXC_W] | result;
            end
        end
    end
endmodule

// File: rtl/fpx_drain_update.sv
module fpx_drain_update
    import fpx_pkg::*;
#(
    parameter int SR_W = 32
) (
    input  logic [SR_W-1:0] cur,
    input  logic            all_ok,
    output logic [SR_W-1:0] nxt
);
    always_comb begin
        nxt = cur;
        nxt[QNE_LSB +: QNE_W] = '0;
        if (all_ok) begin
            nxt[CUR_LSB +: EXC_W] = '0;
        end
    end
endmodule

// File: rtl/fpx_status_rec.sv
module fpx_status_rec
    import fpx_pkg::*;
#(
    parameter int SR_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [SR_W-1:0]  wr_data,
    input  logic             exc_valid,
    input  logic [EXC_W-1:0] exc_vec,
    input  logic             drain_req,
    input  logic             drain_ok,
    output logic [SR_W-1:0]  status_q,
    output logic             trap_req
);
    fpx_state_e      state_q, state_d;
    logic [SR_W-1:0] status_d;
    logic [SR_W-1:0] exc_nxt;
    logic [SR_W-1:0] drn_nxt;
    logic            exc_trap;

    fpx_exc_update #(.SR_W(SR_W)) exc_i (
        .cur  (status_q),
        .vec  (exc_vec),
        .nxt  (exc_nxt),
        .trap (exc_trap)
    );

    fpx_drain_update #(.SR_W(SR_W)) drn_i (
        .cur    (status_q),
        .all_ok (drain_ok),
        .nxt    (drn_nxt)
    );

    // next state and next status: write > exception > drain
    always_comb begin
        state_d  = S_IDLE;
        status_d = status_q;
        if (wr_en) begin
            status_d = wr_data;
            state_d  = S_IDLE;
        end else if (exc_valid) begin
            status_d = exc_nxt;
            unique case (state_q)
                S_IDLE:  state_d = exc_trap ? S_TRAP : S_IDLE;
                S_TRAP:  state_d = exc_trap ? S_TRAP : S_IDLE;
                default: state_d = S_IDLE;
            endcase
        end else if (drain_req) begin
            status_d = drn_nxt;
        end
    end

    // state and status registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= S_IDLE;
            status_q <= '0;
        end else begin
            state_q  <= state_d;
            status_q <= status_d;
        end
    end

    // outputs
    always_comb begin
        unique case (state_q)
            S_TRAP:  trap_req = 1'b1;
            default: trap_req = 1'b0;
        endcase
    end

    AST_TRAP_SINGLE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |-> ($countones(status_q[CUR_LSB +: EXC_W]) == 1)); // R5
    AST_TRAP_TYPE_SET: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |-> (status_q[FTT_LSB +: FTT_W] == 3'b001)); // R7
    AST_TRAP_KEEPS_ACC: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && exc_valid && ((exc_vec & status_q[TEM_LSB +: EXC_W]) != '0))
        |=> $stable(status_q[ACC_LSB +: EXC_W])); // R7
    AST_TRAP_RAISED: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && exc_valid && ((exc_vec & status_q[TEM_LSB +: EXC_W]) != '0))
        |=> trap_req); // R4
    AST_ACC_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && exc_valid)
        |=> ((status_q[ACC_LSB +: EXC_W] & $past(status_q[ACC_LSB +: EXC_W]))
             == $past(status_q[ACC_LSB +: EXC_W]))); // R6
    AST_WRITE_QUIETS_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !trap_req); // R2
    AST_DRAIN_CLEARS_QNE: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !exc_valid && drain_req)
        |=> (status_q[QNE_LSB +: QNE_W] == '0)); // R10
    AST_ZERO_VEC_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && exc_valid && exc_vec == '0)
        |=> (!trap_req && $stable(status_q[FTT_LSB +: FTT_W]))); // R9
endmodule

// File: tb/fpx_status_rec_tb_top.sv
module fpx_status_rec_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        exc_valid = 1'b0;
    logic [4:0]  exc_vec = '0;
    logic        drain_req = 1'b0;
    logic        drain_ok = 1'b0;
    logic [31:0] status_q;
    logic        trap_req;

    int total = 0;
    int bad = 0;
    logic [31:0] exp_st = '0;
    logic        exp_tr = 1'b0;
    string       tag = "R1";

    always #2 clk = ~clk;

    fpx_status_rec dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .exc_valid(exc_valid), .exc_vec(exc_vec), .drain_req(drain_req),
        .drain_ok(drain_ok), .status_q(status_q), .trap_req(trap_req)
    );

    task automatic check32(string rq, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s status act=%08h exp=%08h", rq, act, exp);
        end
    endtask

    task automatic check1(string rq, logic act, logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s trap_req act=%0b exp=%0b", rq, act, exp);
        end
    endtask

    // behavioural reference: apply one cycle of inputs to the expected state
    task automatic model_step(bit w, logic [31:0] wd, bit ev, logic [4:0] v, bit dr, bit ok);
        logic [4:0]  tem, hit, res;
        logic [31:0] s;
        bit          found;
        s = exp_st;
        exp_tr = 1'b0;
        if (w) begin
            s = wd;
        end else if (ev) begin
            tem = s[27:23];
            hit = v & tem;
            res = v;
            if (hit != 0) begin
                found = 0;
                for (int b = 4; b >= 0; b--) begin
                    if (!found && hit[b]) begin
                        res = 5'd0;
                        res[b] = 1'b1;
                        found = 1;
                    end
                end
                exp_tr = 1'b1;
            end
            s[4:0] = res;
            if (v != 0) begin
                s[16:14] = 3'b000;
                if (hit != 0) s[14] = 1'b1;
                else s[9:5] = s[9:5] | res;
            end
        end else if (dr) begin
            s[13:12] = 2'b00;
            if (ok) s[4:0] = 5'd0;
        end
        exp_st = s;
    endtask

    task automatic step(bit w, logic [31:0] wd, bit ev, logic [4:0] v, bit dr, bit ok);
        @(negedge clk);
        wr_en = w; wr_data = wd; exc_valid = ev; exc_vec = v;
        drain_req = dr; drain_ok = ok;
        model_step(w, wd, ev, v, dr, ok);
        @(posedge clk);
        #1;
        check32(tag, status_q, exp_st);
        check1(tag, trap_req, exp_tr);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : stim
        // R1 reset state
        repeat (3) @(posedge clk);
        #1;
        check32("R1", status_q, 32'h0);
        check1("R1", trap_req, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        tag = "R1";
        step(0, 0, 0, 0, 0, 0);

        tag = "R2";
        step(1, 32'h0000_3000, 0, 0, 0, 0);
        check32("R2", status_q, 32'h0000_3000);

        tag = "R6";   // no enables, invalid|underflow: current and accrued set (R3 positions)
        step(0, 0, 1, 5'b10100, 0, 0);
        check32("R6", status_q, 32'h0000_3294);
        check1("R4", trap_req, 1'b0);

        tag = "R9";
        step(0, 0, 1, 5'b00000, 0, 0);
        check32("R9", status_q, 32'h0000_3280);

        tag = "R2";   // write beats exception in the same cycle
        step(1, 32'h0F80_3280, 1, 5'b11111, 0, 0);
        check32("R2", status_q, 32'h0F80_3280);
        check1("R2", trap_req, 1'b0);

        tag = "R5";   // overflow beats underflow and divide-by-zero
        step(0, 0, 1, 5'b01110, 0, 0);
        check32("R5", status_q, 32'h0F80_7288);
        check1("R4", trap_req, 1'b1);
        tag = "R4";
        step(0, 0, 0, 0, 0, 0);
        check1("R4", trap_req, 1'b0);

        tag = "R8";
        step(1, 32'h0800_F000, 0, 0, 0, 0);
        step(0, 0, 1, 5'b00011, 0, 0);

        tag = "R9";
        step(1, 32'h0800_7051, 0, 0, 0, 0);
        step(0, 0, 1, 5'b00000, 0, 0);

        tag = "R7";
        step(0, 0, 1, 5'b10001, 0, 0);
        step(0, 0, 1, 5'b11111, 0, 0);
        tag = "R5";
        step(1, 32'h0080_3000, 0, 0, 0, 0);
        step(0, 0, 1, 5'b00111, 0, 0);

        tag = "R10";
        step(1, 32'h0000_3013, 0, 0, 0, 0);
        step(0, 0, 0, 0, 1, 0);
        step(1, 32'h0000_3013, 0, 0, 0, 0);
        step(0, 0, 0, 0, 1, 1);

        tag = "R11";
        step(1, 32'h0000_3000, 0, 0, 0, 0);
        step(0, 0, 1, 5'b00100, 1, 1);

        tag = "R3";
        for (int n = 0; n < 400; n++) begin
            logic [31:0] rd;
            rd = $urandom;
            step(($urandom % 8) == 0, rd, ($urandom % 2) == 0, 5'($urandom),
                 ($urandom % 3) == 0, ($urandom % 2) == 0);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule